// File: doc/BRIEF.md
# DTMF Transceiver Serial Configuration and Digit Readout Port

This block sits between a host controller and the digital core of a touch-tone transceiver. The host uses a clock line, an enable line, a direction line and one data line that carries traffic both ways. In write direction, the host clocks in a 14-bit control word. The word builds up in a shadow register, and a high level on the enable line copies it into the active configuration. That configuration selects the operating mode, transmit squelch, detection guard time, attenuator or gain step, and tone selection. In read direction, a rising edge on the enable line captures the most recently decoded 4-bit digit. The least significant bit appears on the data line at once, and the remaining bits follow on later clock rising edges.

The host lines are sampled in the system clock domain. Each line passes through a synchroniser chain of configurable length, and edge detectors run on the synchronised clock and enable lines. The split data pin (`ser_data_i`, `ser_data_o`, `ser_data_oe`) maps onto one bidirectional pad at chip level. The block also produces two summary enables, one for tone transmission and one for the receiver, for the analog and detection logic that lies outside this block.

Top module: `scp_port`

## Requirements
- R1: After reset, every configuration output is zero: receive mode (code 000), squelch off, guard 0, gain 0, tone 0. `tx_on_o` is 0, `rx_on_o` is 1 and `ser_data_oe` is 0.
- R2: In write direction (`ser_dir_i`=0), each rising edge of `ser_clk_i` shifts `ser_data_i` into the shadow word, most significant bit first. After 14 edges, the first bit sent is tone bit 3 and the order continues: tone[3:0], gain[3:0], guard[1:0], squelch, mode[2:0]. Mode bit 0 is the last bit sent.
- R3: While `ser_en_i` is high in write direction, the shadow word is copied into the active configuration, and the outputs reflect the new word once EN has been seen.
- R4: While `ser_en_i` is low, shifting a new word in has no effect on any configuration output.
- R5: `mode_o` equals the written mode code for codes 000 to 101. Codes 110 and 111 read out as 100 (full power-down).
- R6: `tx_on_o` is 1 exactly when the mode is 001, 010 or 101 and squelch is 0.
- R7: `rx_on_o` is 1 exactly when the mode is 000 or 101.
- R8: In read direction (`ser_dir_i`=1), a rising edge of `ser_en_i` latches `digit_i`, and `ser_data_o` shows digit bit 0 before any clock edge.
- R9: Each following rising edge of `ser_clk_i` in read direction presents the next digit bit (1, 2, 3). The fifth bit presented is bit 0 again. Changes on `digit_i` without a new EN rising edge do not alter the bits read.
- R10: `ser_data_oe` is 1 while the synchronised direction is read and 0 otherwise. Read activity leaves the active configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Host serial clock (asynchronous) |
| ser_en_i | input | 1 | Host enable: commit level on write, load strobe on read |
| ser_dir_i | input | 1 | Direction: 0 write, 1 read |
| ser_data_i | input | 1 | Serial data from host |
| ser_data_o | output | 1 | Serial data to host |
| ser_data_oe | output | 1 | Output enable for the shared data pad |
| digit_i | input | 4 | Last decoded digit from the detector |
| mode_o | output | 3 | Normalised operating mode code |
| squelch_o | output | 1 | Transmit squelch |
| guard_o | output | 2 | Detect/release guard-time select |
| gain_o | output | 4 | Transmit attenuation / receive gain select |
| tone_o | output | 4 | Tone select |
| tx_on_o | output | 1 | Tone transmission enabled |
| rx_on_o | output | 1 | Receiver enabled |

## Verification
The bench builds the port with a synchroniser depth of 3 instead of the default 2. Every host line then takes one extra cycle to reach the edge detectors, and the bench's hold times on the host lines must still cover the longer latency. That depth also confirms that the serial data bit stays aligned with its clock edge when the chain is longer. Random words reach every mode code, including the two unused ones, with squelch in both states. Directed reads rotate past the fourth bit while `digit_i` changes underneath.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        MD_RX      = 3'b000,
        MD_DTMF_TX = 3'b001,
        MD_TONE_TX = 3'b010,
        MD_PD_OSC  = 3'b011,
        MD_PD_FULL = 3'b100,
        MD_LOOP    = 3'b101
    } mode_e;

    // Packed MSB first: the first bit shifted in lands in tone[3].
    typedef struct packed {
        logic [3:0] tone;
        logic [3:0] gain;
        logic [1:0] guard;
        logic       sq;
        logic [2:0] mode;
    } ctrl_word_t;

    localparam int CTRL_W  = $bits(ctrl_word_t);
    localparam int DIGIT_W = 4;

    function automatic mode_e norm_mode(input logic [2:0] code);
        case (code)
            3'b000:  return MD_RX;
            3'b001:  return MD_DTMF_TX;
            3'b010:  return MD_TONE_TX;
            3'b011:  return MD_PD_OSC;
            3'b101:  return MD_LOOP;
            default: return MD_PD_FULL;
        endcase
    endfunction

    function automatic logic tone_enabled(input mode_e m, input logic sq);
        return (m == MD_DTMF_TX || m == MD_TONE_TX || m == MD_LOOP) && !sq;
    endfunction

    function automatic logic rx_enabled(input mode_e m);
        return (m == MD_RX || m == MD_LOOP);
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    logic [STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= '0;
        end else begin
            pipe[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign sync_o = pipe[STAGES-1];
    assign rise_o = pipe[STAGES-1] & ~prev;

endmodule

// File: rtl/scp_wr_path.sv
module scp_wr_path
    import scp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_i,
    input  logic       bit_i,
    input  logic       commit_i,
    output ctrl_word_t active_o
);
    logic [CTRL_W-1:0] shadow;
    ctrl_word_t        active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (shift_i)  shadow <= {shadow[CTRL_W-2:0], bit_i};
            if (commit_i) active <= ctrl_word_t'(shadow);
        end
    end

    assign active_o = active;

    // R4: with no commit, the active word holds.
    assert_isolate_R4: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(active));

    // R3: a commit that is not accompanied by a shift leaves shadow and active equal.
    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (commit_i && !shift_i) |=> (active == ctrl_word_t'(shadow)));

endmodule

// File: rtl/scp_rd_path.sv
module scp_rd_path
    import scp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               bit_o
);
    logic [DIGIT_W-1:0] status;

    always_ff @(posedge clk) begin
        if (rst)          status <= '0;
        else if (load_i)  status <= digit_i;
        else if (shift_i) status <= {status[0], status[DIGIT_W-1:1]};
    end

    assign bit_o = status[0];

    // R9: without a load or shift, the latched digit holds.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_i) |=> $stable(status));

    // R9: rotation keeps every latched bit.
    assert_rotate_R9: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !load_i) |=> ($countones(status) == $countones($past(status))));

endmodule

// File: rtl/scp_port.sv
module scp_port
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk_i,
    input  logic               ser_en_i,
    input  logic               ser_dir_i,
    input  logic               ser_data_i,
    output logic               ser_data_o,
    output logic               ser_data_oe,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [2:0]         mode_o,
    output logic               squelch_o,
    output logic [1:0]         guard_o,
    output logic [3:0]         gain_o,
    output logic [3:0]         tone_o,
    output logic               tx_on_o,
    output logic               rx_on_o
);
    localparam int IDX_CLK  = 0;
    localparam int IDX_EN   = 1;
    localparam int IDX_DIR  = 2;
    localparam int IDX_DATA = 3;
    localparam int NSIG     = 4;

    logic [NSIG-1:0] raw, syn, rise;
    ctrl_word_t      active;
    mode_e           mode;
    logic            rd_dir;

    assign raw = {ser_data_i, ser_dir_i, ser_en_i, ser_clk_i};

    scp_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw),
        .sync_o  (syn),
        .rise_o  (rise)
    );

    assign rd_dir = syn[IDX_DIR];

    scp_wr_path u_wr (
        .clk      (clk),
        .rst      (rst),
        .shift_i  (rise[IDX_CLK] && !rd_dir),
        .bit_i    (syn[IDX_DATA]),
        .commit_i (syn[IDX_EN] && !rd_dir),
        .active_o (active)
    );

    scp_rd_path u_rd (
        .clk     (clk),
        .rst     (rst),
        .load_i  (rise[IDX_EN] && rd_dir),
        .shift_i (rise[IDX_CLK] && rd_dir),
        .digit_i (digit_i),
        .bit_o   (ser_data_o)
    );

    assign ser_data_oe = rd_dir;
    assign mode        = norm_mode(active.mode);
    assign mode_o      = mode;
    assign squelch_o   = active.sq;
    assign guard_o     = active.guard;
    assign gain_o      = active.gain;
    assign tone_o      = active.tone;
    assign tx_on_o     = tone_enabled(mode, active.sq);
    assign rx_on_o     = rx_enabled(mode);

    // R5: unused codes never reach the mode output.
    assert_mode_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 3'b110) && (mode_o != 3'b111));

    // R6: squelch always blocks transmission.
    assert_squelch_R6: assert property (@(posedge clk) disable iff (rst)
        squelch_o |-> !tx_on_o);

    // R7: transmitter and receiver are both on only in loopback.
    assert_loop_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_on_o && rx_on_o) |-> (mode_o == 3'b101));

    // R10: configuration does not move while the port is reading.
    assert_rdquiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ser_data_oe && $past(ser_data_oe)) |-> $stable(active));

endmodule

// File: tb/scp_port_tb.sv
`timescale 1ns/1ps
module scp_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_en = 1'b0, ser_dir = 1'b0, ser_din = 1'b0;
    logic       ser_dout, ser_oe;
    logic [3:0] digit = 4'h0;
    logic [2:0] mode;
    logic       sq;
    logic [1:0] guard;
    logic [3:0] gain, tone;
    logic       tx_on, rx_on;

    int checks = 0;
    int fails  = 0;
    logic [13:0] cur_word = '0;

    always #2.5 clk = ~clk;

    scp_port #(.SYNC_STAGES(3)) u_dut (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_en_i(ser_en), .ser_dir_i(ser_dir),
        .ser_data_i(ser_din), .ser_data_o(ser_dout), .ser_data_oe(ser_oe),
        .digit_i(digit),
        .mode_o(mode), .squelch_o(sq), .guard_o(guard), .gain_o(gain),
        .tone_o(tone), .tx_on_o(tx_on), .rx_on_o(rx_on)
    );

    function automatic logic [2:0] exp_mode(input logic [2:0] c);
        return (c >= 3'b110) ? 3'b100 : c;
    endfunction
    function automatic logic exp_tx(input logic [2:0] c, input logic s);
        logic [2:0] m = exp_mode(c);
        return (m == 3'b001 || m == 3'b010 || m == 3'b101) && !s;
    endfunction
    function automatic logic exp_rx(input logic [2:0] c);
        logic [2:0] m = exp_mode(c);
        return (m == 3'b000 || m == 3'b101);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Field layout: [13:10] tone, [9:6] gain, [5:4] guard, [3] squelch, [2:0] mode.
    task automatic check_cfg(input string tag, input logic [13:0] w);
        check({tag, " mode"},  32'(mode),  32'(exp_mode(w[2:0])));
        check({tag, " sq"},    32'(sq),    32'(w[3]));
        check({tag, " guard"}, 32'(guard), 32'(w[5:4]));
        check({tag, " gain"},  32'(gain),  32'(w[9:6]));
        check({tag, " tone"},  32'(tone),  32'(w[13:10]));
        check({tag, " tx"},    32'(tx_on), 32'(exp_tx(w[2:0], w[3])));
        check({tag, " rx"},    32'(rx_on), 32'(exp_rx(w[2:0])));
    endtask

    task automatic write_word(input logic [13:0] w);
        ser_dir = 1'b0; ser_en = 1'b0;
        step(6);
        for (int i = 13; i >= 0; i--) begin
            ser_din = w[i];
            step(6);
            ser_clk = 1'b1;
            step(6);
            ser_clk = 1'b0;
            step(6);
        end
        check_cfg("R4 shift without EN", cur_word);
        ser_en = 1'b1;
        step(6);
        ser_en = 1'b0;
        step(6);
        cur_word = w;
        check_cfg("R2 R3 R5 R6 R7 commit", w);
    endtask

    task automatic read_digit(input logic [3:0] d);
        digit = d;
        ser_dir = 1'b1;
        step(6);
        check("R10 oe in read", 32'(ser_oe), 32'd1);
        ser_en = 1'b1;
        step(6);
        check("R8 first bit", 32'(ser_dout), 32'(d[0]));
        digit = ~d;
        ser_en = 1'b0;
        step(6);
        for (int k = 1; k <= 4; k++) begin
            ser_clk = 1'b1;
            step(6);
            ser_clk = 1'b0;
            step(6);
            check("R9 shifted bit", 32'(ser_dout), 32'(d[k % 4]));
        end
        ser_dir = 1'b0;
        step(6);
        check("R10 oe in write", 32'(ser_oe), 32'd0);
        check_cfg("R10 cfg after read", cur_word);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        step(4);
        rst = 1'b0;
        step(2);
        check_cfg("R1 reset", 14'h0);
        check("R1 reset oe", 32'(ser_oe), 32'd0);

        // Every mode code, squelch both ways, plus an all-ones word.
        for (int m = 0; m < 8; m++) begin
            write_word({4'hA, 4'h5, 2'b10, 1'b0, 3'(m)});
            write_word({4'h3, 4'hC, 2'b01, 1'b1, 3'(m)});
        end
        write_word(14'h3FFF);
        write_word(14'h0000);

        read_digit(4'b1011);
        read_digit(4'b0001);
        read_digit(4'b1000);

        for (int r = 0; r < 30; r++) begin
            write_word(14'($urandom));
            if (r % 3 == 0) read_digit(4'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule